// File: doc/BRIEF.md
# Staggered Grayscale PWM Engine

This block turns a bank of 12-bit brightness levels into per-channel on/off enables for a row of LED current sinks. One shared grayscale counter advances on rising edges of a free-running grayscale clock. That clock is brought into the system clock domain by a synchroniser and edge detector. Each channel compares its level against the shared count and is switched on for exactly as many grayscale periods as its level says. A blanking input stops the cycle: it forces all enables off and parks the counter at zero. The next cycle starts when blanking is released.

The edges of each channel's enable are staggered so that the sinks do not all switch in the same clock. Channel n is delayed by n times a fixed step of system clocks, and this applies to both its rising and its falling edge. After a channel has been on for a set number of system clocks, its output-low comparator flag is sampled. If the flag is set while blanking is low, an open-LED fault is latched for that channel. The latched faults stay until the grayscale register is next loaded. An active-low error output combines the latched open faults with a thermal flag. Blanking hides the open-fault part of the error, so only a thermal fault is reported while blanking is high.

All pins are plain levels or single-cycle strobes. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure. The grayscale register is held outside the block and is read continuously.

Top module: `gsp_engine`

## Requirements
- R1: While rst_n is low, chan_en_o and open_o are all zero, and err_n_o is high when therm_i is low.
- R2: A system clock edge with blank_i high clears the grayscale counter to 0. Every chan_en_o bit is 0 after that edge, and the stagger delay lines are emptied.
- R3: With blank_i low, each rising edge of gs_clk_i advances the counter by exactly one. The first rising edge after blanking ends brings the counter to 1.
- R4: Channel n takes its level from gs_word_i[12n+11:12n], with channel 0 in the least significant bits. The channel is on while the counter lies between 1 and its level inclusive, so it stays on for exactly that many grayscale periods. A level of 0 never turns the channel on.
- R5: After 4096 grayscale rises the counter holds in its end state, and every channel stays off until blank_i is raised.
- R6: chan_en_o[n] follows channel 0's timing delayed by n*STEP_CYC system clocks. This holds for both its rising and falling edges.
- R7: open_o[n] is set when three conditions hold at the edge SAMPLE_CYC system clocks after chan_en_o[n] rose: the channel is still on, blank_i is low, and out_low_i[n] is 1. A channel that turns off earlier, or is blanked, is not sampled.
- R8: A latched open_o bit holds until an edge with gs_load_i high, which clears it. A sample that sets the bit on that same edge wins over the clear.
- R9: err_n_o is low exactly when therm_i is high, or when any open_o bit is set while blank_i is low. The output is combinational in those inputs.
- R10: A gs_clk_i rise that is first seen at system edge k changes chan_en_o[0] after edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gs_clk_i | input | 1 | Grayscale clock, asynchronous to clk |
| blank_i | input | 1 | Blanking: all channels off, counter held at zero |
| gs_load_i | input | 1 | Strobe marking a grayscale register load; clears open faults |
| gs_word_i | input | CHANNELS*GS_BITS | Packed grayscale levels, channel 0 lowest |
| out_low_i | input | CHANNELS | Per-channel output-low comparator flags |
| therm_i | input | 1 | Overtemperature flag |
| chan_en_o | output | CHANNELS | Staggered channel enables |
| open_o | output | CHANNELS | Latched open-LED faults |
| err_n_o | output | 1 | Active-low combined error |

## Verification
The two functions that can meet in one cycle are the clear of the open faults by a grayscale load and a new open-fault sample. The bench provokes this by holding gs_load_i high for the whole stretch in which the staggered channels reach their sample points with out_low_i set. That stretch covers many channels, so some channel's sample edge always coincides with a load. A behavioural model in the bench applies set-over-clear and is compared against open_o and err_n_o on every clock. The model only reproduces the fault for a single cycle when the set wins.

// File: rtl/gsp_pkg.sv
package gsp_pkg;
  // stagger applied to a channel, in system clocks
  function automatic int chan_delay(input int idx, input int step);
    return idx * step;
  endfunction
endpackage

// File: rtl/gsp_gs_sync.sv
module gsp_gs_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic gs_clk_i,
  output logic tick_o
);
  // sh[0], sh[1] synchronise; sh[2] remembers the previous synced level
  logic [2:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], gs_clk_i};
  end

  assign tick_o = sh[1] & ~sh[2];
endmodule

// File: rtl/gsp_counter.sv
module gsp_counter #(
  parameter int GS_BITS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blank_i,
  input  logic             tick_i,
  output logic [GS_BITS:0] cnt_o
);
  // one extra bit: the end state sits above every legal level
  localparam logic [GS_BITS:0] END_CNT = {1'b1, {GS_BITS{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt_o <= '0;
    else if (blank_i)                    cnt_o <= '0;
    else if (tick_i && cnt_o != END_CNT) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/gsp_chan.sv
module gsp_chan #(
  parameter int GS_BITS    = 12,
  parameter int DLY        = 0,
  parameter int SAMPLE_CYC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               blank_i,
  input  logic               load_i,
  input  logic               out_low_i,
  input  logic [GS_BITS:0]   cnt_i,
  input  logic [GS_BITS-1:0] level_i,
  output logic               en_o,
  output logic               open_o
);
  localparam int TW = $clog2(SAMPLE_CYC + 1);

  logic raw;
  assign raw = (cnt_i != '0) && (cnt_i <= {1'b0, level_i});

  // stagger line: DLY+1 registers, flushed by blanking
  logic [DLY:0] line;
  generate
    if (DLY == 0) begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       line <= '0;
        else if (blank_i) line <= '0;
        else              line <= raw;
      end
    end else begin : g_shift
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       line <= '0;
        else if (blank_i) line <= '0;
        else              line <= {line[DLY-1:0], raw};
      end
    end
  endgenerate

  assign en_o = line[DLY];

  // open-LED sampling after SAMPLE_CYC clocks of on-time
  logic [TW-1:0] tmr;
  logic          hit;
  assign hit = en_o & ~blank_i & (tmr == TW'(SAMPLE_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr    <= '0;
      open_o <= 1'b0;
    end else begin
      if (!en_o || blank_i)           tmr <= '0;
      else if (tmr != TW'(SAMPLE_CYC)) tmr <= tmr + 1'b1;
      open_o <= (open_o & ~load_i) | (hit & out_low_i);
    end
  end
endmodule

// File: rtl/gsp_engine.sv
module gsp_engine #(
  parameter int CHANNELS   = 16,
  parameter int GS_BITS    = 12,
  parameter int STEP_CYC   = 2,
  parameter int SAMPLE_CYC = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        gs_clk_i,
  input  logic                        blank_i,
  input  logic                        gs_load_i,
  input  logic [CHANNELS*GS_BITS-1:0] gs_word_i,
  input  logic [CHANNELS-1:0]         out_low_i,
  input  logic                        therm_i,
  output logic [CHANNELS-1:0]         chan_en_o,
  output logic [CHANNELS-1:0]         open_o,
  output logic                        err_n_o
);
  logic             tick;
  logic [GS_BITS:0] cnt;

  gsp_gs_sync u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .gs_clk_i (gs_clk_i),
    .tick_o   (tick)
  );

  gsp_counter #(.GS_BITS(GS_BITS)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .blank_i (blank_i),
    .tick_i  (tick),
    .cnt_o   (cnt)
  );

  for (genvar n = 0; n < CHANNELS; n++) begin : g_ch
    gsp_chan #(
      .GS_BITS    (GS_BITS),
      .DLY        (gsp_pkg::chan_delay(n, STEP_CYC)),
      .SAMPLE_CYC (SAMPLE_CYC)
    ) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .blank_i   (blank_i),
      .load_i    (gs_load_i),
      .out_low_i (out_low_i[n]),
      .cnt_i     (cnt),
      .level_i   (gs_word_i[n*GS_BITS +: GS_BITS]),
      .en_o      (chan_en_o[n]),
      .open_o    (open_o[n])
    );
  end

  assign err_n_o = ~(therm_i | ((|open_o) & ~blank_i));
endmodule

// File: rtl/gsp_engine_chk.sv
module gsp_engine_chk #(
  parameter int CHANNELS = 16,
  parameter int GS_BITS  = 12
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        blank_i,
  input logic                        gs_load_i,
  input logic                        therm_i,
  input logic [CHANNELS*GS_BITS-1:0] gs_word_i,
  input logic [CHANNELS-1:0]         chan_en_o,
  input logic [CHANNELS-1:0]         open_o,
  input logic                        err_n_o,
  input logic [GS_BITS:0]            cnt
);
  localparam logic [GS_BITS:0] END_CNT = {1'b1, {GS_BITS{1'b0}}};

  // R2
  blank_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blank_i |=> (chan_en_o == '0));

  // R2
  blank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blank_i |=> (cnt == '0));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_i |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

  // R5
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == END_CNT && !blank_i) |=> (cnt == END_CNT));

  // R4
  zero_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gs_word_i[GS_BITS-1:0]) == '0) |-> !chan_en_o[0]);

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gs_load_i |=> ((open_o & $past(open_o)) == $past(open_o)));

  // R9
  therm_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    therm_i |-> !err_n_o);

  // R9
  clean_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!therm_i && open_o == '0) |-> err_n_o);
endmodule

bind gsp_engine gsp_engine_chk #(.CHANNELS(CHANNELS), .GS_BITS(GS_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .blank_i   (blank_i),
  .gs_load_i (gs_load_i),
  .therm_i   (therm_i),
  .gs_word_i (gs_word_i),
  .chan_en_o (chan_en_o),
  .open_o    (open_o),
  .err_n_o   (err_n_o),
  .cnt       (cnt)
);

// File: tb/gsp_engine_test.sv
`timescale 1ns/1ps
module gsp_engine_test;
  localparam int CH   = 16;
  localparam int GB   = 12;
  localparam int STEP = 2;
  localparam int SMP  = 8;
  localparam int HD   = (CH-1)*STEP + 1;
  localparam int ENDV = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gs_clk = 1'b0;
  logic blank = 1'b1;
  logic load = 1'b0;
  logic [CH*GB-1:0] word = '0;
  logic [CH-1:0] out_low = '0;
  logic therm = 1'b0;
  logic [CH-1:0] en, opn;
  logic err_n;

  gsp_engine #(.CHANNELS(CH), .GS_BITS(GB), .STEP_CYC(STEP), .SAMPLE_CYC(SMP)) uut (
    .clk(clk), .rst_n(rst_n), .gs_clk_i(gs_clk), .blank_i(blank), .gs_load_i(load),
    .gs_word_i(word), .out_low_i(out_low), .therm_i(therm),
    .chan_en_o(en), .open_o(opn), .err_n_o(err_n));

  always #2 clk = ~clk;

  int vectors = 0;
  int misses = 0;
  bit done = 1'b0;
  string tag = "R1";

  // behavioural reference model
  int m_cnt;
  bit gh [0:2];
  logic [CH-1:0] rq [0:HD-1];
  bit bq [0:HD-1];
  int nh;
  logic [CH-1:0] m_en, m_open;
  int m_tmr [0:CH-1];

  function automatic int lvl(input int n);
    return int'(word[n*GB +: GB]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; nh = 0; m_en = '0; m_open = '0;
      for (int i = 0; i < 3; i++) gh[i] = 1'b0;
      for (int i = 0; i < HD; i++) begin rq[i] = '0; bq[i] = 1'b0; end
      for (int n = 0; n < CH; n++) m_tmr[n] = 0;
    end else begin
      logic [CH-1:0] raw, en_prev;
      bit tick, ok, hit;
      int len;
      for (int n = 0; n < CH; n++) raw[n] = (m_cnt >= 1) && (m_cnt <= lvl(n));
      for (int i = HD-1; i > 0; i--) begin rq[i] = rq[i-1]; bq[i] = bq[i-1]; end
      rq[0] = raw; bq[0] = blank;
      if (nh < HD) nh++;
      en_prev = m_en;
      for (int n = 0; n < CH; n++) begin
        len = n*STEP + 1;
        ok = (nh >= len);
        for (int i = 0; i < len; i++) if (bq[i]) ok = 1'b0;
        m_en[n] = ok ? rq[len-1][n] : 1'b0;
      end
      for (int n = 0; n < CH; n++) begin
        hit = en_prev[n] && !blank && (m_tmr[n] == SMP-1);
        if (!en_prev[n] || blank) m_tmr[n] = 0;
        else if (m_tmr[n] != SMP) m_tmr[n]++;
        m_open[n] = (m_open[n] && !load) || (hit && out_low[n]);
      end
      tick = gh[1] && !gh[2];
      gh[2] = gh[1]; gh[1] = gh[0]; gh[0] = gs_clk;
      if (blank) m_cnt = 0;
      else if (tick && m_cnt < ENDV) m_cnt++;
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    logic exp_err;
    if (!done) begin
      vectors++;
      exp_err = ~(therm | ((|m_open) & ~blank));
      if (en !== m_en) begin
        misses++;
        $display("FAIL %s chan_en got %h exp %h at %0t", tag, en, m_en, $time);
      end
      if (opn !== m_open) begin
        misses++;
        $display("FAIL %s open (R7/R8) got %h exp %h at %0t", tag, opn, m_open, $time);
      end
      if (err_n !== exp_err) begin
        misses++;
        $display("FAIL %s err_n (R9) got %b exp %b at %0t", tag, err_n, exp_err, $time);
      end
    end
  end

  task automatic step(input int k);
    repeat (k) begin @(posedge clk); #1; end
  endtask

  task automatic gs_pulses(input int k);
    repeat (k) begin gs_clk = 1'b1; step(2); gs_clk = 1'b0; step(2); end
  endtask

  initial begin
    for (int n = 0; n < CH; n++) word[n*GB +: GB] = GB'(n*2);
    word[1*GB +: GB] = 12'd1;
    step(4);
    // R1 reset state
    vectors++;
    if (en !== '0 || opn !== '0 || err_n !== 1'b1) begin
      misses++;
      $display("FAIL R1 reset got en=%h open=%h err_n=%b exp 0 0 1", en, opn, err_n);
    end
    rst_n = 1'b1;
    tag = "R2";
    gs_pulses(5);
    step(3);
    tag = "R3 R4 R6 R10";
    out_low = 16'hA5A5;
    blank = 1'b0;
    gs_pulses(40);
    tag = "R8";
    blank = 1'b1; step(2);
    load = 1'b1; step(1); load = 1'b0; step(2);
    out_low = '1;
    blank = 1'b0;
    load = 1'b1;
    gs_pulses(10);
    load = 1'b0;
    gs_pulses(30);
    tag = "R9";
    therm = 1'b1; step(3); therm = 1'b0; step(2);
    blank = 1'b1; step(3);
    therm = 1'b1; step(2); therm = 1'b0; step(2);
    tag = "R5 R7";
    for (int n = 0; n < CH; n++) word[n*GB +: GB] = GB'(n*273);
    word[0*GB +: GB] = 12'd4095;
    word[1*GB +: GB] = 12'd4094;
    word[2*GB +: GB] = 12'd1;
    word[3*GB +: GB] = 12'd0;
    load = 1'b1; step(1); load = 1'b0;
    step(2);
    blank = 1'b0;
    gs_pulses(4100);
    step(40);
    gs_pulses(3);
    step(40);
    tag = "R2";
    blank = 1'b1;
    step(5);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      misses++;
      $display("FAIL watchdog expired during %s", tag);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule